// File: doc/BRIEF.md
# Parallel Unrolled LFSR Step Engine

This block advances a linear feedback shift register by one position for every bit of a data word, with all of those shifts done in one combinational pass. It takes the current register contents and a data word, and returns the register contents after the whole word plus an output word holding the feedback bit produced at each shift. The block holds no state. A surrounding wrapper keeps the register and feeds `state_out` back to `state_in` on each accepted word.

Parameters select the register width, the feedback polynomial, the data width, the topology (Fibonacci or Galois), optional bit reversal of the data words, and a feed-forward mode. One engine therefore serves as a CRC generator, a PRBS generator, an additive-free self-synchronous scrambler, or the matching descrambler. The next-state and output functions are XOR masks derived at elaboration time. Each mask is found by stepping the serial register symbolically over the state and data bits.

Top module: `lfsr_step_engine`

## Requirements
- R1: `POLY` leaves out the x^STATE_W term, which the width implies. A configuration of width 32, POLY 0x04C11DB7, Galois, reversal on, starting state all ones, fed the nine ASCII bytes "123456789" one byte per step, leaves a state whose bit-reversed complement is 0xCBF43926.
- R2: The block is combinational and linear. A zero state with zero data gives a zero `state_out` and a zero `data_out`.
- R3: Every evaluation equals exactly DATA_W serial shifts. One step of width 8 matches eight chained steps of width 1 fed the same bits in the same order.
- R4: With TOPOLOGY 0 (Fibonacci), data bits are taken from bit 0 upward. The feedback at each shift is state bit STATE_W-1 XOR state bit k-1 for every set POLY bit k with 1 ≤ k < STATE_W, XOR the data bit. That value is output bit i, and the injected bit enters state bit 0 while the other bits move up by one. State bits at and above DATA_W therefore hold `state_in` shifted up by DATA_W.
- R5: With TOPOLOGY 1 (Galois), data bits are taken from bit DATA_W-1 downward. The feedback is state bit STATE_W-1 XOR the data bit and is output bit i. The next state is the state shifted up by one, XORed with POLY when the injected bit is 1.
- R6: With MIRROR set, `data_in` is bit-reversed before the core and `data_out` after it. The state is never reversed.
- R7: With FEED_FWD set, the injected bit is the incoming data bit rather than the feedback. The output bit is still the feedback.
- R8: A Fibonacci feed-forward instance fed the output of a feedback instance with the same polynomial recovers the original data for every bit after the first STATE_W bits, whatever the two starting states were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | DATA_W | Data word consumed by the shifts |
| state_in | input | STATE_W | Register contents before the step |
| data_out | output | DATA_W | Feedback bit produced at each shift |
| state_out | output | STATE_W | Register contents after DATA_W shifts |

## Verification
The output word and the next state come out of the same evaluation. In Fibonacci mode the bits entering the register are either the output bits or the data bits, so one bad tap corrupts both results at once. The bench drives random states and words into seven configurations and compares both results against a bit-serial model. It also chains `state_out` back into `state_in` across several words, so that a fault in either result shows up on the next word. A scrambler/descrambler pair started from unrelated states checks that feed-forward recovery lands on exactly the bits after the first STATE_W.

// File: rtl/lfsr_step_pkg.sv
package lfsr_step_pkg;

  // Topology selector: Fibonacci taps feed bit 0, Galois feeds taps in-line
  typedef enum logic {
    TOPO_FIBONACCI = 1'b0,
    TOPO_GALOIS    = 1'b1
  } lfsrTopoE;

endpackage

// File: rtl/lfsr_bit_mirror.sv
module lfsr_bit_mirror #(
  parameter int WIDTH  = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [WIDTH-1:0] vecOut
);

  generate
    if (ENABLE) begin : gFlip
      for (genvar b = 0; b < WIDTH; b++) begin : gBit
        assign vecOut[b] = vecIn[WIDTH-1-b];
      end
    end else begin : gPass
      assign vecOut = vecIn;
    end
  endgenerate

endmodule

// File: rtl/lfsr_xor_matrix.sv
module lfsr_xor_matrix
  import lfsr_step_pkg::*;
#(
  parameter int                 STATE_W  = 32,
  parameter int                 DATA_W   = 8,
  parameter logic [STATE_W-1:0] POLY     = 32'h04C11DB7,
  parameter lfsrTopoE           TOPOLOGY = TOPO_GALOIS,
  parameter bit                 FEED_FWD = 1'b0
) (
  input  logic [STATE_W-1:0] stateIn,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [STATE_W-1:0] stateOut,
  output logic [DATA_W-1:0]  dataOut
);

  localparam int NIN  = STATE_W + DATA_W;
  localparam int NOUT = STATE_W + DATA_W;

  // Symbolic serial run: each register stage carries the set of inputs
  // (state bits 0..STATE_W-1, data bits at STATE_W+i) whose XOR it holds.
  function automatic logic [NOUT-1:0][NIN-1:0] buildMask();
    logic [STATE_W-1:0][NIN-1:0] stage;
    logic [NOUT-1:0][NIN-1:0]    res;
    logic [NIN-1:0]              fb;
    logic [NIN-1:0]              inject;
    res   = '0;
    stage = '0;
    for (int k = 0; k < STATE_W; k++) stage[k][k] = 1'b1;
    if (TOPOLOGY == TOPO_GALOIS) begin
      for (int i = DATA_W - 1; i >= 0; i--) begin
        fb = stage[STATE_W-1];
        fb[STATE_W+i] = ~fb[STATE_W+i];
        res[STATE_W+i] = fb;
        inject = fb;
        if (FEED_FWD) begin
          inject = '0;
          inject[STATE_W+i] = 1'b1;
        end
        for (int k = STATE_W - 1; k > 0; k--)
          stage[k] = stage[k-1] ^ (POLY[k] ? inject : '0);
        stage[0] = POLY[0] ? inject : '0;
      end
    end else begin
      for (int i = 0; i < DATA_W; i++) begin
        fb = stage[STATE_W-1];
        for (int k = 1; k < STATE_W; k++)
          if (POLY[k]) fb = fb ^ stage[k-1];
        fb[STATE_W+i] = ~fb[STATE_W+i];
        res[STATE_W+i] = fb;
        inject = fb;
        if (FEED_FWD) begin
          inject = '0;
          inject[STATE_W+i] = 1'b1;
        end
        for (int k = STATE_W - 1; k > 0; k--) stage[k] = stage[k-1];
        stage[0] = inject;
      end
    end
    for (int k = 0; k < STATE_W; k++) res[k] = stage[k];
    return res;
  endfunction

  localparam logic [NOUT-1:0][NIN-1:0] MASK = buildMask();

  logic [NIN-1:0]  vecIn;
  logic [NOUT-1:0] vecOut;

  assign vecIn = {dataIn, stateIn};

  generate
    for (genvar o = 0; o < NOUT; o++) begin : gOut
      assign vecOut[o] = ^(vecIn & MASK[o]);
    end
  endgenerate

  assign stateOut = vecOut[STATE_W-1:0];
  assign dataOut  = vecOut[NOUT-1:STATE_W];

endmodule

// File: rtl/lfsr_step_engine.sv
module lfsr_step_engine
  import lfsr_step_pkg::*;
#(
  parameter int                 STATE_W  = 32,
  parameter logic [STATE_W-1:0] POLY     = 32'h04C11DB7,
  parameter int                 DATA_W   = 8,
  parameter lfsrTopoE           TOPOLOGY = TOPO_GALOIS,
  parameter bit                 MIRROR   = 1'b1,
  parameter bit                 FEED_FWD = 1'b0
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [STATE_W-1:0] state_in,
  output logic [DATA_W-1:0]  data_out,
  output logic [STATE_W-1:0] state_out
);

  logic [DATA_W-1:0] coreDin;
  logic [DATA_W-1:0] coreDout;

  lfsr_bit_mirror #(.WIDTH(DATA_W), .ENABLE(MIRROR)) uMirrorIn (
    .vecIn (data_in),
    .vecOut(coreDin)
  );

  lfsr_xor_matrix #(
    .STATE_W (STATE_W),
    .DATA_W  (DATA_W),
    .POLY    (POLY),
    .TOPOLOGY(TOPOLOGY),
    .FEED_FWD(FEED_FWD)
  ) uMatrix (
    .stateIn (state_in),
    .dataIn  (coreDin),
    .stateOut(state_out),
    .dataOut (coreDout)
  );

  lfsr_bit_mirror #(.WIDTH(DATA_W), .ENABLE(MIRROR)) uMirrorOut (
    .vecIn (coreDout),
    .vecOut(data_out)
  );

  // R2: linear map, zero in gives zero out
  always_comb begin
    if (state_in == '0 && data_in == '0) begin
      p_zero_map_r2: assert (state_out == '0 && data_out == '0)
        else $error("zero inputs produced nonzero outputs");
    end
  end

  generate
    if (TOPOLOGY == TOPO_FIBONACCI) begin : gFibChecks
      if (DATA_W < STATE_W) begin : gShift
        // R4: untouched upper stages move up by DATA_W
        always_comb begin
          p_upper_shift_r4: assert (state_out[STATE_W-1:DATA_W] == state_in[STATE_W-1-DATA_W:0])
            else $error("upper stages not shifted by data width");
        end
      end
      if (DATA_W <= STATE_W) begin : gInject
        // R7: injected bit is the data bit in feed-forward, the feedback otherwise
        always_comb begin
          for (int i = 0; i < DATA_W; i++) begin
            p_inject_bit_r7: assert (state_out[DATA_W-1-i] == (FEED_FWD ? coreDin[i] : coreDout[i]))
              else $error("injected bit mismatch at shift %0d", i);
          end
        end
      end
    end else begin : gGalChecks
      // R5: first shift consumes the top data bit against the top stage
      always_comb begin
        p_first_feedback_r5: assert (coreDout[DATA_W-1] == (state_in[STATE_W-1] ^ coreDin[DATA_W-1]))
          else $error("first Galois feedback wrong");
      end
    end
  endgenerate

endmodule

// File: tb/lfsr_step_engine_test.sv
module lfsr_step_engine_test;
  import lfsr_step_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // cfg0: uut  W32 D8  Galois mirror
  // cfg1: crc1 W32 D1  Galois
  // cfg2: g16  W16 D1  Galois poly 8005
  // cfg3: f16  W16 D8  Fibonacci mirror feed-forward poly 6801
  // cfg4: scr  W58 D64 Fibonacci
  // cfg5: des  W58 D64 Fibonacci feed-forward
  // cfg6: gff  W32 D64 Galois feed-forward
  logic [31:0] uutS, uutSo;  logic [7:0]  uutD, uutDo;
  logic [31:0] c1S, c1So;    logic [0:0]  c1D, c1Do;
  logic [15:0] g16S, g16So;  logic [0:0]  g16D, g16Do;
  logic [15:0] f16S, f16So;  logic [7:0]  f16D, f16Do;
  logic [57:0] scrS, scrSo;  logic [63:0] scrD, scrDo;
  logic [57:0] desS, desSo;  logic [63:0] desD, desDo;
  logic [31:0] gffS, gffSo;  logic [63:0] gffD, gffDo;

  lfsr_step_engine uut (.data_in(uutD), .state_in(uutS), .data_out(uutDo), .state_out(uutSo));
  lfsr_step_engine #(.STATE_W(32), .POLY(32'h04C11DB7), .DATA_W(1), .TOPOLOGY(TOPO_GALOIS),
    .MIRROR(1'b0), .FEED_FWD(1'b0)) uCrc1 (.data_in(c1D), .state_in(c1S), .data_out(c1Do), .state_out(c1So));
  lfsr_step_engine #(.STATE_W(16), .POLY(16'h8005), .DATA_W(1), .TOPOLOGY(TOPO_GALOIS),
    .MIRROR(1'b0), .FEED_FWD(1'b0)) uG16 (.data_in(g16D), .state_in(g16S), .data_out(g16Do), .state_out(g16So));
  lfsr_step_engine #(.STATE_W(16), .POLY(16'h6801), .DATA_W(8), .TOPOLOGY(TOPO_FIBONACCI),
    .MIRROR(1'b1), .FEED_FWD(1'b1)) uF16 (.data_in(f16D), .state_in(f16S), .data_out(f16Do), .state_out(f16So));
  lfsr_step_engine #(.STATE_W(58), .POLY(58'h8000000001), .DATA_W(64), .TOPOLOGY(TOPO_FIBONACCI),
    .MIRROR(1'b0), .FEED_FWD(1'b0)) uScr (.data_in(scrD), .state_in(scrS), .data_out(scrDo), .state_out(scrSo));
  lfsr_step_engine #(.STATE_W(58), .POLY(58'h8000000001), .DATA_W(64), .TOPOLOGY(TOPO_FIBONACCI),
    .MIRROR(1'b0), .FEED_FWD(1'b1)) uDes (.data_in(desD), .state_in(desS), .data_out(desDo), .state_out(desSo));
  lfsr_step_engine #(.STATE_W(32), .POLY(32'h04C11DB7), .DATA_W(64), .TOPOLOGY(TOPO_GALOIS),
    .MIRROR(1'b0), .FEED_FWD(1'b1)) uGff (.data_in(gffD), .state_in(gffS), .data_out(gffDo), .state_out(gffSo));

  function automatic void cfgInfo(input int cfg, output int w, output int d, output logic [63:0] poly,
                                  output bit gal, output bit ff, output bit rev);
    case (cfg)
      0: begin w = 32; d = 8;  poly = 64'h04C11DB7;   gal = 1; ff = 0; rev = 1; end
      1: begin w = 32; d = 1;  poly = 64'h04C11DB7;   gal = 1; ff = 0; rev = 0; end
      2: begin w = 16; d = 1;  poly = 64'h8005;       gal = 1; ff = 0; rev = 0; end
      3: begin w = 16; d = 8;  poly = 64'h6801;       gal = 0; ff = 1; rev = 1; end
      4: begin w = 58; d = 64; poly = 64'h8000000001; gal = 0; ff = 0; rev = 0; end
      5: begin w = 58; d = 64; poly = 64'h8000000001; gal = 0; ff = 1; rev = 0; end
      default: begin w = 32; d = 64; poly = 64'h04C11DB7; gal = 1; ff = 1; rev = 0; end
    endcase
  endfunction

  function automatic logic [63:0] widthMask(input int n);
    return (n >= 64) ? '1 : ((64'h1 << n) - 64'h1);
  endfunction

  // Bit-serial reference, one register shift per data bit
  function automatic void refStep(input int cfg, input logic [63:0] stIn, input logic [63:0] dIn,
                                  output logic [63:0] stOut, output logic [63:0] dOut);
    int w, d; logic [63:0] poly; bit gal, ff, rev;
    logic [63:0] s, din, dout;
    logic fb, inj;
    cfgInfo(cfg, w, d, poly, gal, ff, rev);
    s = stIn & widthMask(w);
    din = '0; dout = '0;
    for (int i = 0; i < d; i++) din[i] = rev ? dIn[d-1-i] : dIn[i];
    if (gal) begin
      for (int i = d - 1; i >= 0; i--) begin
        fb = s[w-1] ^ din[i];
        dout[i] = fb;
        inj = ff ? din[i] : fb;
        s = (s << 1) & widthMask(w);
        if (inj) s = s ^ (poly & widthMask(w));
      end
    end else begin
      for (int i = 0; i < d; i++) begin
        fb = s[w-1];
        for (int k = 1; k < w; k++) if (poly[k]) fb = fb ^ s[k-1];
        fb = fb ^ din[i];
        dout[i] = fb;
        inj = ff ? din[i] : fb;
        s = ((s << 1) | {63'b0, inj}) & widthMask(w);
      end
    end
    stOut = s;
    dOut = '0;
    for (int i = 0; i < d; i++) dOut[i] = rev ? dout[d-1-i] : dout[i];
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int cfg, input logic [63:0] s, input logic [63:0] d,
                       output logic [63:0] so, output logic [63:0] dout);
    @(posedge clk);
    #1;
    case (cfg)
      0: begin uutS = s[31:0]; uutD = d[7:0]; end
      1: begin c1S = s[31:0]; c1D = d[0:0]; end
      2: begin g16S = s[15:0]; g16D = d[0:0]; end
      3: begin f16S = s[15:0]; f16D = d[7:0]; end
      4: begin scrS = s[57:0]; scrD = d; end
      5: begin desS = s[57:0]; desD = d; end
      default: begin gffS = s[31:0]; gffD = d; end
    endcase
    @(negedge clk);
    case (cfg)
      0: begin so = {32'b0, uutSo}; dout = {56'b0, uutDo}; end
      1: begin so = {32'b0, c1So}; dout = {63'b0, c1Do}; end
      2: begin so = {48'b0, g16So}; dout = {63'b0, g16Do}; end
      3: begin so = {48'b0, f16So}; dout = {56'b0, f16Do}; end
      4: begin so = {6'b0, scrSo}; dout = scrDo; end
      5: begin so = {6'b0, desSo}; dout = desDo; end
      default: begin so = {32'b0, gffSo}; dout = gffDo; end
    endcase
  endtask

  function automatic string reqOf(input int cfg);
    case (cfg)
      0: return "R6";
      1, 2: return "R5";
      3: return "R7";
      4: return "R4";
      5: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin : stim
    logic [63:0] so, dout, eso, edout, st, crc;
    logic [63:0] scrState, desState, word;
    logic [63:0] orig [4];
    logic [7:0] msg [9];
    int w, d; logic [63:0] poly; bit gal, ff, rev;
    void'($urandom(32'h1F2E3D4C));
    uutS = '0; uutD = '0; c1S = '0; c1D = '0; g16S = '0; g16D = '0; f16S = '0; f16D = '0;
    scrS = '0; scrD = '0; desS = '0; desD = '0; gffS = '0; gffD = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R2: zero state and data give zero outputs, in both topologies
    for (int cfg = 0; cfg < 7; cfg++) begin
      apply(cfg, '0, '0, so, dout);
      check("R2", "zero state_out", so, '0);
      check("R2", "zero data_out", dout, '0);
    end

    // R1: CRC-32 check value over "123456789"
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    st = 64'hFFFFFFFF;
    for (int i = 0; i < 9; i++) begin
      apply(0, st, {56'b0, msg[i]}, so, dout);
      st = so;
    end
    crc = '0;
    for (int k = 0; k < 32; k++) crc[k] = ~st[31-k];
    check("R1", "crc32 check value", crc, 64'hCBF43926);

    // R3 and R6: one mirrored byte step equals eight 1-bit steps fed bit 0 first
    for (int t = 0; t < 20; t++) begin
      logic [63:0] s0, byteVal, chained, bitOut, serialOut, byteOut;
      s0 = {32'b0, $urandom()};
      byteVal = {56'b0, 8'($urandom())};
      if (t == 0) begin s0 = 64'hFFFFFFFF; byteVal = 64'hFF; end
      if (t == 1) begin s0 = 64'h80000000; byteVal = 64'h00; end
      chained = s0; serialOut = '0;
      for (int b = 0; b < 8; b++) begin
        apply(1, chained, {63'b0, byteVal[b]}, chained, bitOut);
        serialOut[b] = bitOut[0];
      end
      apply(0, s0, byteVal, so, byteOut);
      check("R3", "byte step vs chained bits state", so, chained);
      check("R6", "mirrored output order", byteOut, serialOut);
    end

    // R4 R5 R7 R6: random states and words against the serial model, all configs
    for (int cfg = 0; cfg < 7; cfg++) begin
      cfgInfo(cfg, w, d, poly, gal, ff, rev);
      for (int t = 0; t < 120; t++) begin
        logic [63:0] s0, d0;
        s0 = {$urandom(), $urandom()} & widthMask(w);
        d0 = {$urandom(), $urandom()} & widthMask(d);
        if (t == 0) s0 = widthMask(w);
        if (t == 1) d0 = widthMask(d);
        if (t == 2) begin s0 = 64'h1 << (w - 1); d0 = '0; end
        refStep(cfg, s0, d0, eso, edout);
        apply(cfg, s0, d0, so, dout);
        check(reqOf(cfg), "state_out vs serial model", so, eso);
        check(reqOf(cfg), "data_out vs serial model", dout, edout);
      end
    end

    // R8: descrambler recovers data after the first 58 bits from any start state
    for (int run = 0; run < 4; run++) begin
      scrState = {$urandom(), $urandom()} & widthMask(58);
      desState = {$urandom(), $urandom()} & widthMask(58);
      if (run == 0) desState = '0;
      for (int k = 0; k < 4; k++) orig[k] = {$urandom(), $urandom()};
      for (int k = 0; k < 4; k++) begin
        apply(4, scrState, orig[k], scrState, word);
        apply(5, desState, word, desState, dout);
        if (k == 0)
          check("R8", "first word tail recovered", dout & ~widthMask(58), orig[k] & ~widthMask(58));
        else
          check("R8", "later word recovered", dout, orig[k]);
      end
    end

    finished = 1;
    finishRun();
  end

endmodule